// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block turns one CPU-style bus request into a single active-low chip select for one of five memory-mapped targets: a boot ROM, a small RAM, a larger ROM and two peripherals with two bytes each. It watches a 24-bit address, separate read and write strobes and a transfer-size code. It holds the chosen select for a number of wait states set for that target, then pulses a ready signal that ends the bus cycle. The master keeps its strobe and address stable until it sees ready, and then drops the strobe.

A compile-time parameter picks one of two decoding styles. Full decoding compares every upper address bit against a fixed, irregular map and leaves large holes. A hole still gets a ready after one cycle with zero read data, so the bus cannot hang. Partial decoding looks only at the two or three most significant bits. This makes every target alias across the whole space and leaves no holes.

Read data from the targets arrives on a shared input. The block passes it through while a mapped target is selected and forces it to zero otherwise. A transfer whose last byte lands in a different target than its first byte is treated as unmapped in both modes.

Top module: `bus_addr_decoder`

## Requirements
- R1: While reset is active, and in the cycles before the first request, all five selects are high (inactive), ready is low and read data is zero.
- R2: In full mode, addresses 0x000000 to 0x0007FF select target 0 (boot ROM) and 0x000800 to 0x000FFF select target 1 (RAM). Select bit i of `cs_n` belongs to target i.
- R3: In full mode, 0x004000 to 0x005FFF select target 2 (large ROM), 0x008000 to 0x008001 select target 3 (peripheral A) and 0x008002 to 0x008003 select target 4 (peripheral B).
- R4: In full mode, any other address asserts no select and gives ready in the cycle right after the request is first sampled.
- R5: In partial mode, only the top address bits decide the target: 000 gives target 0, 001 gives target 1, 01 gives target 2, 10 gives target 3 and 11 gives target 4. All lower bits are ignored, so every target aliases across the space.
- R6: At no cycle is more than one select low.
- R7: A request is sampled at a rising edge while the bus is idle. The select goes low in the next cycle, and ready is high for exactly one cycle, W+1 cycles after the sampling edge. W is the wait-state count of the target (defaults: target 0 = 2, 1 = 0, 2 = 3, 3 = 1, 4 = 4). The select stays low up to and including the ready cycle and is high in the cycle after it.
- R8: While a mapped target is selected, read data equals the target data input. In the ready cycle of an unmapped access, read data is zero.
- R9: Size code s (0 to 3) means 2^s bytes starting at the address. If the last byte decodes to a different target than the first, or runs past 0xFFFFFF, the access is unmapped.
- R10: Reads and writes decode and time identically. Either strobe high while idle starts an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_size | input | 2 | Transfer size code, 2^code bytes |
| tgt_rdata | input | 16 | Shared read data from the targets |
| cs_n | output | 5 | Active-low selects, bit i for target i |
| bus_ready | output | 1 | One-cycle end-of-transfer pulse |
| bus_rdata | output | 16 | Read data returned to the master |

## Verification
The bench probes the first and last byte of every full-mode region and the first byte of each hole around them. A comparator off by one bit would select a target one byte too early or too late, or miss a peripheral pair. Multi-byte accesses that straddle a region edge, or wrap past the top of the space, must come back unmapped. A decoder that checks only the first byte would select a target whose range the transfer overruns. In partial mode, addresses that full mode leaves unmapped or places elsewhere must alias onto targets by their top bits alone. Ready latency is measured per target, so a counter that is off by one, or that never loads for a hole, shows up as a wrong cycle count or a hung bus.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  localparam int unsigned NUM_TGT = 5;
  localparam int unsigned TGT_W   = 3;

  // Target codes: code i drives select bit i; TGT_NONE selects nothing.
  typedef enum logic [TGT_W-1:0] {
    TGT_ROM1  = 3'd0,
    TGT_RAM   = 3'd1,
    TGT_ROM2  = 3'd2,
    TGT_PERA  = 3'd3,
    TGT_PERB  = 3'd4,
    TGT_NONE  = 3'd5
  } tgt_e;

endpackage

// File: rtl/addr_region_map.sv
module addr_region_map
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              region
);

  generate
    if (FULL_DECODE) begin : g_full
      // Every address bit above the region offset must match.
      always_comb begin
        if ((addr >> 11) == '0) begin
          region = TGT_ROM1;
        end else if ((addr >> 11) == ADDR_W'(1)) begin
          region = TGT_RAM;
        end else if ((addr >> 13) == ADDR_W'(2)) begin
          region = TGT_ROM2;
        end else if ((addr >> 1) == ADDR_W'(16'h4000)) begin
          region = TGT_PERA;
        end else if ((addr >> 1) == ADDR_W'(16'h4001)) begin
          region = TGT_PERB;
        end else begin
          region = TGT_NONE;
        end
      end
    end else begin : g_part
      // Only the top bits take part; the space is covered with aliases.
      always_comb begin
        unique case (addr[ADDR_W-1 -: 2])
          2'b00:   region = addr[ADDR_W-3] ? TGT_RAM : TGT_ROM1;
          2'b01:   region = TGT_ROM2;
          2'b10:   region = TGT_PERA;
          default: region = TGT_PERB;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/xfer_span_decode.sv
module xfer_span_decode
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned SIZE_W      = 2,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output tgt_e              region
);

  localparam int unsigned SPAN_W = ADDR_W + 1;

  logic [SPAN_W-1:0] last_byte;
  logic [ADDR_W-1:0] last_addr;
  logic              wrap;
  tgt_e              first_reg;
  tgt_e              last_reg;

  always_comb begin
    last_byte = {1'b0, addr} + (SPAN_W'(1) << size) - SPAN_W'(1);
    last_addr = last_byte[ADDR_W-1:0];
    wrap      = last_byte[ADDR_W];
  end

  addr_region_map #(
    .ADDR_W      (ADDR_W),
    .FULL_DECODE (FULL_DECODE)
  ) u_first (
    .addr   (addr),
    .region (first_reg)
  );

  addr_region_map #(
    .ADDR_W      (ADDR_W),
    .FULL_DECODE (FULL_DECODE)
  ) u_last (
    .addr   (last_addr),
    .region (last_reg)
  );

  always_comb begin
    if (wrap || (first_reg != last_reg)) begin
      region = TGT_NONE;
    end else begin
      region = first_reg;
    end
  end

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import addr_dec_pkg::*;
#(
  parameter int unsigned                 CNT_W    = 3,
  parameter logic [NUM_TGT*CNT_W-1:0]    WAIT_VEC = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  tgt_e region_in,
  output logic busy,
  output tgt_e region_q,
  output logic ready
);

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e              st_q, st_d;
  tgt_e             reg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             reg_en;

  function automatic logic [CNT_W-1:0] wait_of(input tgt_e r);
    if (r == TGT_NONE) begin
      return '0;
    end
    return WAIT_VEC[int'(r)*CNT_W +: CNT_W];
  endfunction

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    reg_d  = region_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    reg_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d   = ST_BUSY;
          reg_d  = region_in;
          reg_en = 1'b1;
          cnt_d  = wait_of(region_in);
          cnt_en = 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q - CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      region_q <= TGT_NONE;
      cnt_q    <= '0;
    end else begin
      st_q <= st_d;
      if (reg_en) begin
        region_q <= reg_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy  = (st_q == ST_BUSY);
  assign ready = busy && (cnt_q == '0);

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1))); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R7
  AST_REGION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> (busy && $stable(region_q))); // R7

endmodule

// File: rtl/chip_select_drive.sv
module chip_select_drive
  import addr_dec_pkg::*;
#(
  parameter int unsigned N_SEL = NUM_TGT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  tgt_e             region,
  output logic [N_SEL-1:0] cs_n
);

  generate
    for (genvar gi = 0; gi < N_SEL; gi++) begin : g_sel
      assign cs_n[gi] = ~(busy && (region == TGT_W'(gi)));
    end
  endgenerate

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R6
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n)); // R7

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SIZE_W      = 2,
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned WAIT_ROM1   = 2,
  parameter int unsigned WAIT_RAM    = 0,
  parameter int unsigned WAIT_ROM2   = 3,
  parameter int unsigned WAIT_PERA   = 1,
  parameter int unsigned WAIT_PERB   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [SIZE_W-1:0]   bus_size,
  input  logic [DATA_W-1:0]   tgt_rdata,
  output logic [NUM_TGT-1:0]  cs_n,
  output logic                bus_ready,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int unsigned MAX_A    = (WAIT_ROM1 > WAIT_RAM)  ? WAIT_ROM1 : WAIT_RAM;
  localparam int unsigned MAX_B    = (WAIT_ROM2 > WAIT_PERA) ? WAIT_ROM2 : WAIT_PERA;
  localparam int unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_WAIT = (MAX_C > WAIT_PERB) ? MAX_C : WAIT_PERB;
  localparam int unsigned CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam logic [NUM_TGT*CNT_W-1:0] WAIT_VEC = {
    CNT_W'(WAIT_PERB), CNT_W'(WAIT_PERA), CNT_W'(WAIT_ROM2),
    CNT_W'(WAIT_RAM),  CNT_W'(WAIT_ROM1)
  };

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  tgt_e       dec_region;
  tgt_e       region_q;
  logic       busy;
  logic       req;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  assign req = bus_rd | bus_wr;

  xfer_span_decode #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .FULL_DECODE (FULL_DECODE)
  ) u_span (
    .addr   (bus_addr),
    .size   (bus_size),
    .region (dec_region)
  );

  xfer_sequencer #(
    .CNT_W    (CNT_W),
    .WAIT_VEC (WAIT_VEC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req       (req),
    .region_in (dec_region),
    .busy      (busy),
    .region_q  (region_q),
    .ready     (bus_ready)
  );

  chip_select_drive #(
    .N_SEL (NUM_TGT)
  ) u_cs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .busy   (busy),
    .region (region_q),
    .cs_n   (cs_n)
  );

  always_comb begin
    if (busy && (region_q != TGT_NONE)) begin
      bus_rdata = tgt_rdata;
    end else begin
      bus_rdata = '0;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_ready && (&cs_n)) |-> (bus_rdata == '0)); // R8
  AST_SELECTED_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!(&cs_n)) |-> (bus_rdata == tgt_rdata)); // R8
  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(bus_ready) |-> $past(req)); // R10

endmodule

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;

  localparam int W_ROM1 = 2;
  localparam int W_RAM  = 0;
  localparam int W_ROM2 = 3;
  localparam int W_PERA = 1;
  localparam int W_PERB = 4;

  typedef struct {
    logic [4:0]  cs;
    int          lat;
    logic [15:0] rd;
    int          start;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [23:0] addr;
  logic [1:0]  size;
  logic        f_rd, f_wr, p_rd, p_wr;
  logic [15:0] tgt_data;
  logic [4:0]  f_cs_n, p_cs_n;
  logic        f_ready, p_ready;
  logic [15:0] f_rdata, p_rdata;

  int   cyc;
  int   checks;
  int   failures;
  exp_t q_full[$];
  exp_t q_part[$];

  assign tgt_data = addr[15:0] ^ 16'h3C5A;

  bus_addr_decoder #(
    .FULL_DECODE (1'b1),
    .WAIT_ROM1 (W_ROM1), .WAIT_RAM (W_RAM), .WAIT_ROM2 (W_ROM2),
    .WAIT_PERA (W_PERA), .WAIT_PERB (W_PERB)
  ) uut (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_rd (f_rd),
    .bus_wr (f_wr), .bus_size (size), .tgt_rdata (tgt_data),
    .cs_n (f_cs_n), .bus_ready (f_ready), .bus_rdata (f_rdata)
  );

  bus_addr_decoder #(
    .FULL_DECODE (1'b0),
    .WAIT_ROM1 (W_ROM1), .WAIT_RAM (W_RAM), .WAIT_ROM2 (W_ROM2),
    .WAIT_PERA (W_PERA), .WAIT_PERB (W_PERB)
  ) uut_part (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_rd (p_rd),
    .bus_wr (p_wr), .bus_size (size), .tgt_rdata (tgt_data),
    .cs_n (p_cs_n), .bus_ready (p_ready), .bus_rdata (p_rdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wait_for(input int t);
    case (t)
      0: return W_ROM1;
      1: return W_RAM;
      2: return W_ROM2;
      3: return W_PERA;
      4: return W_PERB;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops an expected item on each ready pulse and compares it.
  task automatic score(input bit part, input logic [4:0] cs, input logic [15:0] rd);
    exp_t e;
    if (part ? (q_part.size() == 0) : (q_full.size() == 0)) begin
      checks++;
      failures++;
      $display("FAIL R7 unexpected ready actual=1 expected=0");
      return;
    end
    e = part ? q_part.pop_front() : q_full.pop_front();
    check(e.tag, "select", 32'(cs), 32'(e.cs));
    check(e.tag, "latency", 32'(cyc - e.start), 32'(e.lat));
    check(e.tag, "rdata", 32'(rd), 32'(e.rd));
    check("R6", "one select", 32'($countones(~cs) <= 1), 32'd1);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (f_ready) score(1'b0, f_cs_n, f_rdata);
      if (p_ready) score(1'b1, p_cs_n, p_rdata);
    end
  end

  // Driver: pushes the expected item, drives the request, waits for ready.
  task automatic xfer(input bit part, input logic [23:0] a, input bit is_wr,
                      input logic [1:0] sz, input int tgt, input string tag);
    exp_t e;
    int   guard;
    bit   rdy;
    @(negedge clk);
    e.cs    = (tgt == 5) ? 5'h1F : ~(5'b00001 << tgt);
    e.lat   = wait_for(tgt) + 1;
    e.rd    = (tgt == 5) ? 16'h0000 : (a[15:0] ^ 16'h3C5A);
    e.start = cyc;
    e.tag   = tag;
    if (part) q_part.push_back(e);
    else      q_full.push_back(e);
    addr = a;
    size = sz;
    if (part) begin p_rd = !is_wr; p_wr = is_wr; end
    else      begin f_rd = !is_wr; f_wr = is_wr; end
    guard = 0;
    rdy   = 1'b0;
    while (!rdy && guard < 50) begin
      @(negedge clk);
      rdy = part ? p_ready : f_ready;
      guard++;
    end
    f_rd = 1'b0; f_wr = 1'b0; p_rd = 1'b0; p_wr = 1'b0;
    if (!rdy) begin
      check(tag, "ready seen", 32'd0, 32'd1);
    end
    @(negedge clk);
    check("R7", "select released", 32'(part ? p_cs_n : f_cs_n), 32'h1F);
  endtask

  initial begin
    cyc = 0; checks = 0; failures = 0;
    rst_n = 1'b0; addr = '0; size = '0;
    f_rd = 1'b0; f_wr = 1'b0; p_rd = 1'b0; p_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset selects", 32'({f_cs_n, p_cs_n}), 32'h3FF);
    check("R1", "reset ready", 32'({f_ready, p_ready}), 32'd0);
    check("R1", "reset rdata", 32'(f_rdata), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle selects", 32'({f_cs_n, p_cs_n}), 32'h3FF);

    // Full map, low regions
    xfer(0, 24'h000000, 0, 2'd0, 0, "R2");
    xfer(0, 24'h0007FF, 0, 2'd0, 0, "R2");
    xfer(0, 24'h000800, 0, 2'd0, 1, "R2");
    xfer(0, 24'h000FFF, 1, 2'd0, 1, "R2");
    xfer(0, 24'h0007FE, 0, 2'd1, 0, "R2");
    // Full map, upper regions
    xfer(0, 24'h004000, 0, 2'd0, 2, "R3");
    xfer(0, 24'h005FFF, 1, 2'd0, 2, "R3");
    xfer(0, 24'h008000, 0, 2'd0, 3, "R3");
    xfer(0, 24'h008001, 1, 2'd0, 3, "R3");
    xfer(0, 24'h008002, 0, 2'd0, 4, "R3");
    xfer(0, 24'h008003, 1, 2'd0, 4, "R3");
    xfer(0, 24'h008002, 0, 2'd1, 4, "R3");
    // Holes
    xfer(0, 24'h001000, 0, 2'd0, 5, "R4");
    xfer(0, 24'h003FFF, 0, 2'd0, 5, "R4");
    xfer(0, 24'h006000, 0, 2'd0, 5, "R4");
    xfer(0, 24'h008004, 0, 2'd0, 5, "R4");
    xfer(0, 24'h100000, 0, 2'd0, 5, "R4");
    xfer(0, 24'h800000, 1, 2'd0, 5, "R10");
    // Transfers running over a region edge
    xfer(0, 24'h0007FF, 0, 2'd1, 5, "R9");
    xfer(0, 24'h000FFE, 0, 2'd2, 5, "R9");
    xfer(0, 24'h008001, 1, 2'd1, 5, "R9");
    xfer(0, 24'h004000, 0, 2'd3, 2, "R9");
    // Partial map with aliasing
    xfer(1, 24'h000800, 0, 2'd0, 0, "R5");
    xfer(1, 24'h1FFFFF, 0, 2'd0, 0, "R5");
    xfer(1, 24'h123456, 1, 2'd0, 0, "R5");
    xfer(1, 24'h200000, 0, 2'd0, 1, "R5");
    xfer(1, 24'h3FFFFF, 1, 2'd0, 1, "R5");
    xfer(1, 24'h400000, 0, 2'd0, 2, "R5");
    xfer(1, 24'h7FFFFF, 0, 2'd0, 2, "R5");
    xfer(1, 24'h800000, 0, 2'd0, 3, "R5");
    xfer(1, 24'hBFFFFF, 1, 2'd0, 3, "R5");
    xfer(1, 24'hC00000, 0, 2'd0, 4, "R5");
    xfer(1, 24'hFFFFFF, 1, 2'd0, 4, "R10");
    xfer(1, 24'h1FFFFF, 0, 2'd1, 5, "R9");
    xfer(1, 24'hFFFFFF, 0, 2'd1, 5, "R9");
    xfer(1, 24'h3FFFFC, 0, 2'd2, 1, "R9");

    repeat (3) @(negedge clk);
    check("R8", "pending items", 32'(q_full.size() + q_part.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule